// File: doc/BRIEF.md
# Per-Virtual-Channel Credit Flow Control Link

This block sits on one link between two routers and keeps the sender honest about buffer space at the receiver. On the sending side it holds a separate credit counter for every virtual channel of the receiving port. Each counter starts at the receiver's per-channel buffer depth. A flit may leave only on a channel whose counter is above zero, and each flit that leaves takes one credit. On the receiving side, each time a flit is drained from a channel buffer and its slot is free again, the block produces a credit for that channel. The credit is tagged with the channel number and goes back to the matching counter.

The credit return path passes through a delay line of configurable length, which stands in for the wire and pipeline latency of a real credit loop. When the buffer depth does not cover this round trip, a channel cannot sustain one flit per cycle even with a drain that never stalls. This makes the cost of shallow buffers visible directly at the ports. Route computation, channel allocation and the crossbar are outside this block.

Top module: `vcCreditLink`

## Requirements
- R1: After reset every counter equals BUF_DEPTH. The count of channel i is on creditCount[i*CNT_W +: CNT_W], where CNT_W = $clog2(BUF_DEPTH+1). Every creditAvail bit is 1 and creditValid is 0.
- R2: When sendReq is high and the count of channel sendVc (binary index 0..NUM_VC-1) is nonzero, sendGrant is 1 in that same cycle. That channel's count is one lower from the next cycle on, unless R6 applies.
- R3: While a channel's count is zero, its creditAvail bit is 0. A sendReq on that channel gets sendGrant 0 and the count stays at zero.
- R4: A grant on one channel leaves the counts of all other channels unchanged.
- R5: A credit with creditValid 1 and creditVc = v raises the count of channel v by one from the next cycle on, unless R6 applies.
- R6: A grant and a returning credit on the same channel in the same cycle leave that count unchanged. When they are on different channels, both counts update.
- R7: A popValid in cycle c with popVc = v shows as creditValid 1 with creditVc = v in cycle c+RET_DELAY-1 (the same cycle when RET_DELAY is 1). The count of v is higher from cycle c+RET_DELAY.
- R8: No count ever exceeds BUF_DEPTH. A credit arriving for a full channel without a same-cycle grant is a protocol error and is flagged.
- R9: With the drain popping each granted flit in its grant cycle, one channel sustains a grant every cycle when BUF_DEPTH >= RET_DELAY. Otherwise it gets BUF_DEPTH grants in every RET_DELAY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sendReq | input | 1 | Sender has a flit for channel sendVc |
| sendVc | input | VC_W | Channel of the flit to send |
| sendGrant | output | 1 | Flit is forwarded this cycle and a credit is consumed |
| creditAvail | output | NUM_VC | Per-channel nonzero-count flags |
| creditCount | output | NUM_VC*CNT_W | All counters, channel 0 in the low bits |
| popValid | input | 1 | Receiver freed one buffer slot this cycle |
| popVc | input | VC_W | Channel whose slot was freed |
| creditValid | output | 1 | Credit arriving at the counters this cycle |
| creditVc | output | VC_W | Channel of the arriving credit |

## Verification
A flit grant and a delayed credit can land on the same channel counter in one cycle. The bench provokes this by issuing a pop exactly RET_DELAY-1 cycles before a send on that channel, so the credit appears on creditValid in the grant cycle. The count seen the next cycle must equal the count before, with no net change. The same timing aimed at two different channels must move both counts, one down and one up.

// File: rtl/vcCreditPkg.sv
`timescale 1ns/1ps
package vcCreditPkg;
  // Width of channel ids carried inside the strobe bundle; supports up to 16 channels.
  localparam int VcIdW = 4;

  typedef struct packed {
    logic             decEn;
    logic [VcIdW-1:0] decVc;
    logic             incEn;
    logic [VcIdW-1:0] incVc;
  } creditStrobes_t;
endpackage

// File: rtl/creditReturnPipe.sv
`timescale 1ns/1ps
module creditReturnPipe #(
  parameter int VC_W      = 2,
  parameter int RET_DELAY = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [VC_W-1:0] inVc,
  output logic            outValid,
  output logic [VC_W-1:0] outVc
);
  // A credit becomes usable RET_DELAY cycles after the pop; the counter update
  // itself costs one edge, so the line holds RET_DELAY-1 stages.
  if (RET_DELAY <= 1) begin : gPass
    assign outValid = inValid;
    assign outVc    = inVc;
  end else begin : gPipe
    localparam int STAGES = RET_DELAY - 1;
    logic [STAGES-1:0] vld;
    logic [VC_W-1:0]   vcs [STAGES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld <= '0;
      end else begin
        vld[0] <= inValid;
        for (int s = 1; s < STAGES; s++) vld[s] <= vld[s-1];
      end
    end

    always_ff @(posedge clk) begin
      vcs[0] <= inVc;
      for (int s = 1; s < STAGES; s++) vcs[s] <= vcs[s-1];
    end

    assign outValid = vld[STAGES-1];
    assign outVc    = vcs[STAGES-1];
  end
endmodule

// File: rtl/creditCtrl.sv
`timescale 1ns/1ps
module creditCtrl
  import vcCreditPkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2
) (
  input  logic              sendReq,
  input  logic [VC_W-1:0]   sendVc,
  input  logic [NUM_VC-1:0] creditAvail,
  input  logic              retValid,
  input  logic [VC_W-1:0]   retVc,
  output logic              sendGrant,
  output creditStrobes_t    strobes
);
  logic vcInRange;
  assign vcInRange = (int'(sendVc) < NUM_VC);

  always_comb begin
    sendGrant     = sendReq && vcInRange && creditAvail[sendVc];
    strobes.decEn = sendGrant;
    strobes.decVc = VcIdW'(sendVc);
    strobes.incEn = retValid;
    strobes.incVc = VcIdW'(retVc);
  end
endmodule

// File: rtl/creditBank.sv
`timescale 1ns/1ps
module creditBank
  import vcCreditPkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  creditStrobes_t          strobes,
  output logic [NUM_VC*CNT_W-1:0] creditCount,
  output logic [NUM_VC-1:0]       creditAvail
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_DEPTH);

  for (genvar v = 0; v < NUM_VC; v++) begin : gVc
    logic [CNT_W-1:0] cnt;
    logic             take, give;

    assign take = strobes.decEn && (strobes.decVc == VcIdW'(v));
    assign give = strobes.incEn && (strobes.incVc == VcIdW'(v));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= FULL;
      end else if (give && !take && cnt != FULL) begin
        cnt <= cnt + 1'b1;
      end else if (take && !give && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign creditCount[v*CNT_W +: CNT_W] = cnt;
    assign creditAvail[v]                = (cnt != '0);
  end
endmodule

// File: rtl/vcCreditLink.sv
`timescale 1ns/1ps
module vcCreditLink
  import vcCreditPkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int BUF_DEPTH = 4,
  parameter int RET_DELAY = 3,
  localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sendReq,
  input  logic [VC_W-1:0]         sendVc,
  output logic                    sendGrant,
  output logic [NUM_VC-1:0]       creditAvail,
  output logic [NUM_VC*CNT_W-1:0] creditCount,
  input  logic                    popValid,
  input  logic [VC_W-1:0]         popVc,
  output logic                    creditValid,
  output logic [VC_W-1:0]         creditVc
);
  creditStrobes_t strobes;

  creditReturnPipe #(.VC_W(VC_W), .RET_DELAY(RET_DELAY)) uPipe (
    .clk(clk), .rstN(rstN),
    .inValid(popValid), .inVc(popVc),
    .outValid(creditValid), .outVc(creditVc)
  );

  creditCtrl #(.NUM_VC(NUM_VC), .VC_W(VC_W)) uCtrl (
    .sendReq(sendReq), .sendVc(sendVc), .creditAvail(creditAvail),
    .retValid(creditValid), .retVc(creditVc),
    .sendGrant(sendGrant), .strobes(strobes)
  );

  creditBank #(.NUM_VC(NUM_VC), .BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) uBank (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .creditCount(creditCount), .creditAvail(creditAvail)
  );
endmodule

// File: rtl/vcCreditLinkChk.sv
`timescale 1ns/1ps
module vcCreditLinkChk #(
  parameter int NUM_VC    = 4,
  parameter int BUF_DEPTH = 4,
  parameter int VC_W      = 2,
  parameter int CNT_W     = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    sendReq,
  input logic [VC_W-1:0]         sendVc,
  input logic                    sendGrant,
  input logic [NUM_VC*CNT_W-1:0] creditCount,
  input logic                    creditValid,
  input logic [VC_W-1:0]         creditVc
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_DEPTH);

  logic [CNT_W-1:0] cntArr [NUM_VC];
  always_comb for (int i = 0; i < NUM_VC; i++) cntArr[i] = creditCount[i*CNT_W +: CNT_W];

  logic [VC_W-1:0]  pSendVc, pRetVc;
  logic [CNT_W-1:0] pSendCnt, pRetCnt;
  always_ff @(posedge clk) begin
    pSendVc  <= sendVc;
    pRetVc   <= creditVc;
    pSendCnt <= cntArr[sendVc];
    pRetCnt  <= cntArr[creditVc];
  end

  logic sameVc;
  assign sameVc = sendGrant && creditValid && (sendVc == creditVc);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    creditValid && !sameVc |-> cntArr[creditVc] != FULL);  // R8
  AST_NO_SEND_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    sendGrant |-> sendReq && cntArr[sendVc] != '0);  // R3
  AST_DEC_ON_SEND: assert property (@(posedge clk) disable iff (!rstN)
    sendGrant && !sameVc |=> cntArr[pSendVc] == pSendCnt - 1'b1);  // R2
  AST_INC_ON_CREDIT: assert property (@(posedge clk) disable iff (!rstN)
    creditValid && !sameVc |=> cntArr[pRetVc] == pRetCnt + 1'b1);  // R5
  AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    sameVc |=> cntArr[pSendVc] == pSendCnt);  // R6
endmodule

bind vcCreditLink vcCreditLinkChk #(
  .NUM_VC(NUM_VC), .BUF_DEPTH(BUF_DEPTH), .VC_W(VC_W), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .sendReq(sendReq), .sendVc(sendVc),
  .sendGrant(sendGrant), .creditCount(creditCount),
  .creditValid(creditValid), .creditVc(creditVc)
);

// File: tb/vcCreditLink_test.sv
`timescale 1ns/1ps
module vcCreditLink_test;
  localparam int NV = 4, DP = 4, DL = 3, CW = $clog2(DP + 1);
  localparam int SNV = 2, SDP = 2, SDL = 4, SCW = $clog2(SDP + 1);
  localparam int WIN = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 8 ns period

  logic rstN;
  logic sendReq; logic [1:0] sendVc; logic sendGrant;
  logic [NV-1:0] creditAvail; logic [NV*CW-1:0] creditCount;
  logic popValid; logic [1:0] popVc; logic creditValid; logic [1:0] creditVc;
  logic manPop; logic [1:0] manPopVc; logic loopOn;

  assign popValid = manPop | (loopOn & sendGrant);
  assign popVc    = loopOn ? sendVc : manPopVc;

  vcCreditLink #(.NUM_VC(NV), .BUF_DEPTH(DP), .RET_DELAY(DL)) uut (
    .clk(clk), .rstN(rstN), .sendReq(sendReq), .sendVc(sendVc), .sendGrant(sendGrant),
    .creditAvail(creditAvail), .creditCount(creditCount),
    .popValid(popValid), .popVc(popVc), .creditValid(creditValid), .creditVc(creditVc));

  logic sReq; logic [0:0] sVc; logic sGrant; logic [SNV-1:0] sAvail;
  logic [SNV*SCW-1:0] sCount; logic sCredV; logic [0:0] sCredVc;

  vcCreditLink #(.NUM_VC(SNV), .BUF_DEPTH(SDP), .RET_DELAY(SDL)) uutShallow (
    .clk(clk), .rstN(rstN), .sendReq(sReq), .sendVc(sVc), .sendGrant(sGrant),
    .creditAvail(sAvail), .creditCount(sCount),
    .popValid(sGrant), .popVc(sVc), .creditValid(sCredV), .creditVc(sCredVc));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cntOf(int v);
    return int'(creditCount[v*CW +: CW]);
  endfunction

  function automatic int expGrants(int depth, int dly, int n);
    if (depth >= dly) return n;
    return (n / dly) * depth + ((n % dly) < depth ? (n % dly) : depth);
  endfunction

  task automatic idle();
    sendReq = 0; sendVc = 0; manPop = 0; manPopVc = 0; loopOn = 0; sReq = 0; sVc = 0;
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic tReset();
    @(negedge clk); #1;
    for (int v = 0; v < NV; v++) check("R1", cntOf(v), DP, "count after reset");
    check("R1", int'(creditAvail), (1 << NV) - 1, "creditAvail after reset");
    check("R1", int'(creditValid), 0, "creditValid after reset");
  endtask

  task automatic tDrain();
    for (int i = 0; i < DP; i++) begin
      @(negedge clk); sendReq = 1; sendVc = 2; #1;
      check("R2", int'(sendGrant), 1, "grant with credit");
      check("R2", cntOf(2), DP - i, "count before send");
    end
    @(negedge clk); #1;
    check("R3", cntOf(2), 0, "count after drain");
    check("R3", int'(creditAvail[2]), 0, "avail at zero");
    check("R3", int'(sendGrant), 0, "grant at zero");
    @(negedge clk); #1;
    check("R3", cntOf(2), 0, "count held at zero");
    check("R4", cntOf(0) + cntOf(1) + cntOf(3), 3 * DP, "other channels untouched");
    sendReq = 0;
  endtask

  task automatic tRefill();
    @(negedge clk); manPop = 1; manPopVc = 2; #1;
    check("R7", int'(creditValid), 0, "no credit in pop cycle");
    @(negedge clk); manPop = 0; #1;
    check("R7", int'(creditValid), 0, "no credit one cycle after pop");
    @(negedge clk); #1;
    check("R7", int'(creditValid), 1, "credit valid after delay");
    check("R7", int'(creditVc), 2, "credit channel");
    check("R7", cntOf(2), 0, "count not yet raised");
    @(negedge clk); #1;
    check("R5", cntOf(2), 1, "count raised by credit");
    check("R7", int'(creditValid), 0, "credit is one cycle");
    for (int i = 1; i < DP; i++) begin
      @(negedge clk); manPop = 1; manPopVc = 2;
    end
    @(negedge clk); manPop = 0;
    repeat (DL + 2) @(negedge clk);
    #1;
    check("R8", cntOf(2), DP, "refilled to depth");
    check("R8", int'(creditAvail), (1 << NV) - 1, "all available");
  endtask

  task automatic tSameCycle();
    @(negedge clk); sendReq = 1; sendVc = 1;
    @(negedge clk); sendReq = 0; manPop = 1; manPopVc = 1; #1;
    check("R2", cntOf(1), DP - 1, "one credit taken");
    @(negedge clk); manPop = 0;
    @(negedge clk); sendReq = 1; sendVc = 1; #1;
    check("R6", int'(creditValid && sendGrant && creditVc == 2'd1), 1, "credit and grant coincide");
    @(negedge clk); sendReq = 0; manPop = 1; manPopVc = 1; #1;
    check("R6", cntOf(1), DP - 1, "same-channel count unchanged");
    @(negedge clk); manPop = 0;
    @(negedge clk); sendReq = 1; sendVc = 0; #1;
    check("R6", int'(creditValid && sendGrant && creditVc == 2'd1), 1, "credit ch1 with grant ch0");
    @(negedge clk); sendReq = 0; manPop = 1; manPopVc = 0; #1;
    check("R6", cntOf(1), DP, "ch1 raised");
    check("R6", cntOf(0), DP - 1, "ch0 lowered");
    @(negedge clk); manPop = 0;
    repeat (DL + 1) @(negedge clk);
    #1;
    check("R8", cntOf(0), DP, "ch0 back at depth");
  endtask

  task automatic tThroughput();
    int gDeep = 0, gShallow = 0;
    doReset();
    @(negedge clk); loopOn = 1; sendReq = 1; sendVc = 0; sReq = 1; sVc = 0;
    for (int i = 0; i < WIN; i++) begin
      #1;
      gDeep += int'(sendGrant);
      gShallow += int'(sGrant);
      @(negedge clk);
    end
    sendReq = 0; sReq = 0;
    check("R9", gDeep, expGrants(DP, DL, WIN), "grants, depth covers delay");
    check("R9", gShallow, expGrants(SDP, SDL, WIN), "grants, shallow buffer");
    repeat (SDL + 2) @(negedge clk);
    #1;
    check("R8", cntOf(0), DP, "deep count settles at depth");
    check("R8", int'(sCount[0 +: SCW]), SDP, "shallow count settles at depth");
    loopOn = 0;
  endtask

  initial begin
    doReset();
    tReset();
    tDrain();
    tRefill();
    tSameCycle();
    tThroughput();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule